// File: doc/BRIEF.md
# Masked Data Value Comparator

This block watches load/store traffic on a 32-bit data bus and flags a data match against software-programmed reference values. It holds two comparator units. Each unit looks only at the byte lanes that the current access actually drives, given its size and the two low address bits. Inside those lanes it applies its own compare width, per-byte ignore bits and a compare condition. Magnitude conditions use either unsigned or two's-complement numbers.

The two unit results can also be joined. An AND join gives an inside-a-range detector when one unit tests `x > lower` and the other tests `x < upper`. An OR join gives an outside-a-range detector when one unit tests `x < lower` and the other tests `x > upper`. The data is taken exactly as it stands on the bus lanes, with no byte reordering. All results are registered single-cycle pulses.

Top module: `ldv_range_match`

## Requirements
- R1: While `rst_n` is low, every hit output is low, whatever the inputs.
- R2: Hit outputs are registered. The result for a bus cycle appears on the clock edge that samples `bus_valid` high and lasts one cycle. The edge after a cycle with `bus_valid` low shows all hits low.
- R3: Lanes are big-endian. Lane i (i = 0..3) is `bus_data[31-8i -: 8]` and lane 0 sits at address offset 0. `bus_size` encodes 0 = byte, 1 = half-word, 2 = word and 3 = none. A byte access at offset a drives lane a. An aligned half-word at offset a drives lanes a and a+1. A word at offset 0 drives all four lanes.
- R4: A half-word at an odd offset, a word at a nonzero offset, or `bus_size` = 3 never gives any hit.
- R5: A unit's `cfg_mode` sets its compare window: 0 = the byte lane at the offset, 1 = the aligned lane pair containing the offset, 2 = all four lanes, 3 = unit disabled. The effective bytes are the window lanes that are driven by the access and not ignored. A unit with no effective byte gives no hit.
- R6: Bit i of `cfg_ignore` set to 1 removes lane i from the unit's compare. That byte's value in the data and in the reference never changes the result.
- R7: `cfg_cond` encodes 0 = equal, 1 = not equal, 2 = data greater than reference, 3 = data less than reference. Both operands are taken from the same lanes.
- R8: For magnitude conditions, bytes outside the effective set count as zero. The window field is then widened to 32 bits. The widening uses sign extension from the top bit of the window when `cfg_signed` is 1, and zero extension when it is 0. Both operands are compared as two's-complement when `cfg_signed` is 1.
- R9: `cfg_join` encodes 0 or 3 = `hit_pair` stays low, 1 = `hit_pair` is the AND of both unit results, 2 = `hit_pair` is the OR of both unit results. `hit_pair` uses the same bus cycle and follows the R2 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A load/store data beat is on the bus this cycle |
| bus_data | input | 32 | Data as it stands on the bus lanes |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 none |
| bus_addr_lo | input | 2 | Two low address bits of the access |
| cfg_ref | input | 2x32 | Reference value per unit, laid out lane for lane like the bus |
| cfg_cond | input | 2x2 | Compare condition per unit |
| cfg_mode | input | 2x2 | Compare window per unit |
| cfg_ignore | input | 2x4 | Byte-lane ignore bits per unit |
| cfg_signed | input | 1 | Two's-complement magnitude compares when 1 |
| cfg_join | input | 2 | How the two unit results form `hit_pair` |
| hit_cmp | output | 2 | Per-unit registered match pulse |
| hit_pair | output | 1 | Registered joined match pulse |

## Verification
The assertions check on every cycle the rules that need no arithmetic. Hits are quiet after an idle cycle, after a misaligned or sizeless access, for a disabled unit and for a unit with every lane ignored. The join settings that force `hit_pair` low or tie it to both unit results are also covered there. The value-dependent behaviour can only be shown by the bench's sweeps. That covers lane selection by offset, narrowing to the window, zeroing of ignored bytes, and the ordering under signed and unsigned readings. The bench compares these against an arithmetic model across all sizes, offsets, windows, conditions and signedness settings.

// File: rtl/ldv_pkg.sv
package ldv_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        WIN_BYTE = 2'd0,
        WIN_HALF = 2'd1,
        WIN_WORD = 2'd2,
        WIN_OFF  = 2'd3
    } win_mode_e;

    typedef enum logic [1:0] {
        COND_EQ = 2'd0,
        COND_NE = 2'd1,
        COND_GT = 2'd2,
        COND_LT = 2'd3
    } cmp_cond_e;

    typedef enum logic [1:0] {
        JOIN_OFF    = 2'd0,
        JOIN_BOTH   = 2'd1,
        JOIN_EITHER = 2'd2,
        JOIN_RSVD   = 2'd3
    } join_mode_e;

endpackage

// File: rtl/ldv_lane_gate.sv
module ldv_lane_gate
    import ldv_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic [1:0]           acc_size,
    input  logic [1:0]           addr_lo,
    output logic [NUM_LANES-1:0] lane_ok
);

    always_comb begin
        lane_ok = '0;
        unique case (acc_size_e'(acc_size))
            SZ_BYTE: lane_ok[addr_lo] = 1'b1;
            SZ_HALF: begin
                if (!addr_lo[0]) begin
                    lane_ok[{addr_lo[1], 1'b0}] = 1'b1;
                    lane_ok[{addr_lo[1], 1'b1}] = 1'b1;
                end
            end
            SZ_WORD: begin
                if (addr_lo == 2'd0) lane_ok = '1;
            end
            default: lane_ok = '0;
        endcase
    end

endmodule

// File: rtl/ldv_cmp_unit.sv
module ldv_cmp_unit
    import ldv_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4
) (
    input  logic [LANE_W*NUM_LANES-1:0] data_in,
    input  logic [LANE_W*NUM_LANES-1:0] ref_in,
    input  logic [NUM_LANES-1:0]        lane_ok,
    input  logic [1:0]                  addr_lo,
    input  logic [1:0]                  mode,
    input  logic [1:0]                  cond,
    input  logic [NUM_LANES-1:0]        ignore,
    input  logic                        is_signed,
    output logic                        hit
);

    localparam int DW = LANE_W * NUM_LANES;

    logic [NUM_LANES-1:0] win;
    logic [NUM_LANES-1:0] eff;
    logic [1:0]           low_lane;
    logic [DW-1:0]        dz;
    logic [DW-1:0]        rz;
    logic [DW-1:0]        d_sh;
    logic [DW-1:0]        r_sh;
    logic [DW-1:0]        d_ext;
    logic [DW-1:0]        r_ext;
    logic [DW-1:0]        d_key;
    logic [DW-1:0]        r_key;
    logic                 res;

    // window of the compare and lowest-order lane inside it
    always_comb begin
        win      = '0;
        low_lane = 2'd3;
        unique case (win_mode_e'(mode))
            WIN_BYTE: begin
                win[addr_lo] = 1'b1;
                low_lane     = addr_lo;
            end
            WIN_HALF: begin
                win[{addr_lo[1], 1'b0}] = 1'b1;
                win[{addr_lo[1], 1'b1}] = 1'b1;
                low_lane                = {addr_lo[1], 1'b1};
            end
            WIN_WORD: begin
                win      = '1;
                low_lane = 2'd3;
            end
            default: win = '0;
        endcase
    end

    assign eff = win & lane_ok & ~ignore;

    // zero every byte outside the effective set, in both operands
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign dz[DW-1-LANE_W*i -: LANE_W] = eff[i] ? data_in[DW-1-LANE_W*i -: LANE_W] : '0;
        assign rz[DW-1-LANE_W*i -: LANE_W] = eff[i] ? ref_in[DW-1-LANE_W*i -: LANE_W]  : '0;
    end

    // move the window to the bottom and widen it
    always_comb begin
        int shamt;
        logic d_sign;
        logic r_sign;
        shamt = (NUM_LANES - 1 - int'(low_lane)) * LANE_W;
        d_sh  = dz >> shamt;
        r_sh  = rz >> shamt;
        unique case (win_mode_e'(mode))
            WIN_BYTE: begin
                d_sign = is_signed & d_sh[LANE_W-1];
                r_sign = is_signed & r_sh[LANE_W-1];
                d_ext  = {{(DW-LANE_W){d_sign}}, d_sh[LANE_W-1:0]};
                r_ext  = {{(DW-LANE_W){r_sign}}, r_sh[LANE_W-1:0]};
            end
            WIN_HALF: begin
                d_sign = is_signed & d_sh[2*LANE_W-1];
                r_sign = is_signed & r_sh[2*LANE_W-1];
                d_ext  = {{(DW-2*LANE_W){d_sign}}, d_sh[2*LANE_W-1:0]};
                r_ext  = {{(DW-2*LANE_W){r_sign}}, r_sh[2*LANE_W-1:0]};
            end
            default: begin
                d_sign = 1'b0;
                r_sign = 1'b0;
                d_ext  = d_sh;
                r_ext  = r_sh;
            end
        endcase
        // flipping the top bit turns a signed order into an unsigned one
        d_key = {d_ext[DW-1] ^ is_signed, d_ext[DW-2:0]};
        r_key = {r_ext[DW-1] ^ is_signed, r_ext[DW-2:0]};
    end

    always_comb begin
        unique case (cmp_cond_e'(cond))
            COND_EQ: res = (dz == rz);
            COND_NE: res = (dz != rz);
            COND_GT: res = (d_key > r_key);
            default: res = (d_key < r_key);
        endcase
    end

    assign hit = (|eff) & res;

endmodule

// File: rtl/ldv_range_match.sv
module ldv_range_match
    import ldv_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 4,
    parameter int NUM_CMP   = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     bus_valid,
    input  logic [LANE_W*NUM_LANES-1:0]              bus_data,
    input  logic [1:0]                               bus_size,
    input  logic [1:0]                               bus_addr_lo,
    input  logic [NUM_CMP-1:0][LANE_W*NUM_LANES-1:0] cfg_ref,
    input  logic [NUM_CMP-1:0][1:0]                  cfg_cond,
    input  logic [NUM_CMP-1:0][1:0]                  cfg_mode,
    input  logic [NUM_CMP-1:0][NUM_LANES-1:0]        cfg_ignore,
    input  logic                                     cfg_signed,
    input  logic [1:0]                               cfg_join,
    output logic [NUM_CMP-1:0]                       hit_cmp,
    output logic                                     hit_pair
);

    typedef struct packed {
        logic [NUM_CMP-1:0] unit_hit;
        logic               pair_hit;
    } hit_state_t;

    hit_state_t           state_d;
    hit_state_t           state_q;
    logic [NUM_LANES-1:0] lane_ok;
    logic [NUM_CMP-1:0]   raw_hit;

    ldv_lane_gate #(
        .NUM_LANES (NUM_LANES)
    ) i_lane_gate (
        .acc_size (bus_size),
        .addr_lo  (bus_addr_lo),
        .lane_ok  (lane_ok)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_unit
        ldv_cmp_unit #(
            .LANE_W    (LANE_W),
            .NUM_LANES (NUM_LANES)
        ) i_cmp_unit (
            .data_in   (bus_data),
            .ref_in    (cfg_ref[g]),
            .lane_ok   (lane_ok),
            .addr_lo   (bus_addr_lo),
            .mode      (cfg_mode[g]),
            .cond      (cfg_cond[g]),
            .ignore    (cfg_ignore[g]),
            .is_signed (cfg_signed),
            .hit       (raw_hit[g])
        );

        // R6: a unit with every lane ignored never reports
        assert_all_ignored_quiet_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ignore[g] == '1) |=> !hit_cmp[g]);

        // R5: a disabled window never reports
        assert_window_off_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[g] == 2'd3) |=> !hit_cmp[g]);
    end

    always_comb begin
        state_d          = '0;
        state_d.unit_hit = bus_valid ? raw_hit : '0;
        unique case (join_mode_e'(cfg_join))
            JOIN_BOTH:   state_d.pair_hit = bus_valid & (&raw_hit);
            JOIN_EITHER: state_d.pair_hit = bus_valid & (|raw_hit);
            default:     state_d.pair_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign hit_cmp  = state_q.unit_hit;
    assign hit_pair = state_q.pair_hit;

    // R2: an idle cycle is followed by quiet outputs
    assert_idle_quiet_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (hit_cmp == '0) && !hit_pair);

    // R4: misaligned or sizeless accesses never report
    assert_misaligned_quiet_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_size == 2'd1 && bus_addr_lo[0]) ||
         (bus_size == 2'd2 && bus_addr_lo != 2'd0) ||
         (bus_size == 2'd3)) |=> (hit_cmp == '0) && !hit_pair);

    // R9: an off join keeps the pair output low
    assert_join_off_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_join == 2'd0 || cfg_join == 2'd3) |=> !hit_pair);

    // R9: an AND join follows both unit outputs
    assert_join_both_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_join == 2'd1) |=> (hit_pair == (&hit_cmp)));

endmodule

// File: tb/test_ldv_range_match.sv
module test_ldv_range_match;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bus_valid;
    logic [31:0]      bus_data;
    logic [1:0]       bus_size;
    logic [1:0]       bus_addr_lo;
    logic [1:0][31:0] cfg_ref;
    logic [1:0][1:0]  cfg_cond;
    logic [1:0][1:0]  cfg_mode;
    logic [1:0][3:0]  cfg_ignore;
    logic             cfg_signed;
    logic [1:0]       cfg_join;
    logic [1:0]       hit_cmp;
    logic             hit_pair;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ldv_range_match i_ldv_range_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_data    (bus_data),
        .bus_size    (bus_size),
        .bus_addr_lo (bus_addr_lo),
        .cfg_ref     (cfg_ref),
        .cfg_cond    (cfg_cond),
        .cfg_mode    (cfg_mode),
        .cfg_ignore  (cfg_ignore),
        .cfg_signed  (cfg_signed),
        .cfg_join    (cfg_join),
        .hit_cmp     (hit_cmp),
        .hit_pair    (hit_pair)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (size=%0d off=%0d data=%h)",
                     tag, act, exp, bus_size, bus_addr_lo, bus_data);
        end
    endtask

    // arithmetic model of one unit
    function automatic bit model_hit(logic [31:0] d, logic [31:0] r, int sz, int off,
                                     int md, int cd, logic [3:0] ign, bit sg);
        int vs, vl, ws, wl, n;
        longint dv, rv, span;
        if (sz == 0) begin vs = off; vl = 1; end
        else if (sz == 1 && off % 2 == 0) begin vs = off; vl = 2; end
        else if (sz == 2 && off == 0) begin vs = 0; vl = 4; end
        else return 1'b0;
        if (md == 0) begin ws = off; wl = 1; end
        else if (md == 1) begin ws = off - off % 2; wl = 2; end
        else if (md == 2) begin ws = 0; wl = 4; end
        else return 1'b0;
        n = 0; dv = 0; rv = 0;
        for (int j = ws; j < ws + wl; j++) begin
            bit on;
            on = (j >= vs) && (j < vs + vl) && !ign[j];
            dv = dv * 256 + (on ? longint'(d[31-8*j -: 8]) : 0);
            rv = rv * 256 + (on ? longint'(r[31-8*j -: 8]) : 0);
            if (on) n++;
        end
        if (n == 0) return 1'b0;
        if (sg) begin
            span = longint'(1) << (8 * wl);
            if (dv >= span / 2) dv -= span;
            if (rv >= span / 2) rv -= span;
        end
        case (cd)
            0: return dv == rv;
            1: return dv != rv;
            2: return dv > rv;
            default: return dv < rv;
        endcase
    endfunction

    task automatic set_unit(input int k, input logic [31:0] r, input int md, input int cd,
                            input logic [3:0] ign);
        cfg_ref[k]    = r;
        cfg_mode[k]   = 2'(md);
        cfg_cond[k]   = 2'(cd);
        cfg_ignore[k] = ign;
    endtask

    task automatic beat(input logic [31:0] d, input int sz, input int off);
        @(negedge clk);
        bus_valid   = 1'b1;
        bus_data    = d;
        bus_size    = 2'(sz);
        bus_addr_lo = 2'(off);
        @(negedge clk);
    endtask

    initial begin
        #1500000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] dpat [4];
        logic [31:0] rpat [4];
        logic [3:0]  ipat [4];
        dpat[0] = 32'h80FF7F01; rpat[0] = 32'h7F0180FF; ipat[0] = 4'b0000;
        dpat[1] = 32'h12345678; rpat[1] = 32'h12345678; ipat[1] = 4'b0000;
        dpat[2] = 32'hFF00FF00; rpat[2] = 32'h00FF00FF; ipat[2] = 4'b1001;
        dpat[3] = 32'hA5C3E1F0; rpat[3] = 32'hA5C30000; ipat[3] = 4'b0100;

        rst_n = 1'b0; bus_valid = 1'b1; bus_data = 32'h11223344;
        bus_size = 2'd2; bus_addr_lo = 2'd0; cfg_signed = 1'b0; cfg_join = 2'd2;
        set_unit(0, 32'h11223344, 2, 0, 4'h0);
        set_unit(1, 32'h11223344, 2, 0, 4'h0);
        repeat (3) @(negedge clk);
        // R1: reset holds outputs low even with a matching beat applied
        check("R1 unit0", hit_cmp[0], 1'b0);
        check("R1 unit1", hit_cmp[1], 1'b0);
        check("R1 pair", hit_pair, 1'b0);
        rst_n = 1'b1;

        // R2: one cycle pulse, then quiet when the strobe drops
        beat(32'h11223344, 2, 0);
        check("R2 hit", hit_cmp[0], 1'b1);
        bus_valid = 1'b0;
        @(negedge clk);
        check("R2 idle", hit_cmp[0], 1'b0);
        check("R2 idle pair", hit_pair, 1'b0);

        // R3: byte access picks the lane at its offset
        set_unit(0, 32'h1122AB33, 0, 0, 4'h0);
        set_unit(1, 32'h0, 3, 0, 4'h0);
        beat(32'h0000AB00, 0, 2);
        check("R3 lane2", hit_cmp[0], 1'b1);
        beat(32'h0000AB00, 0, 1);
        check("R3 lane1", hit_cmp[0], 1'b0);

        // R4: misaligned accesses never report
        set_unit(0, 32'h11223344, 2, 0, 4'h0);
        set_unit(1, 32'h11223344, 1, 0, 4'h0);
        beat(32'h11223344, 1, 1);
        check("R4 half odd", hit_cmp[1], 1'b0);
        beat(32'h11223344, 2, 2);
        check("R4 word off", hit_cmp[0], 1'b0);
        check("R4 pair", hit_pair, 1'b0);
        beat(32'h11223344, 2, 0);
        check("R4 word aligned", hit_cmp[0], 1'b1);

        // R5: a half window on a byte access uses only the driven lane; mode 3 is off
        set_unit(0, 32'h55660000, 1, 0, 4'h0);
        set_unit(1, 32'h55000000, 3, 0, 4'h0);
        beat(32'h55000000, 0, 0);
        check("R5 narrow", hit_cmp[0], 1'b1);
        check("R5 off", hit_cmp[1], 1'b0);

        // R6: ignored lane cannot spoil an equal; all ignored gives nothing
        set_unit(0, 32'h11223344, 2, 0, 4'b1000);
        set_unit(1, 32'h11223344, 2, 0, 4'b1111);
        beat(32'h112233EE, 2, 0);
        check("R6 lane3 ignored", hit_cmp[0], 1'b1);
        check("R6 all ignored", hit_cmp[1], 1'b0);

        // R8: 0xFF versus 0x01 under both readings
        set_unit(0, 32'h01000000, 0, 2, 4'h0);
        set_unit(1, 32'h01000000, 0, 3, 4'h0);
        cfg_signed = 1'b0;
        beat(32'hFF000000, 0, 0);
        check("R8 unsigned gt", hit_cmp[0], 1'b1);
        cfg_signed = 1'b1;
        beat(32'hFF000000, 0, 0);
        check("R8 signed gt", hit_cmp[0], 1'b0);
        check("R8 signed lt", hit_cmp[1], 1'b1);

        // R7 / R9: sweep against the model
        for (int p = 0; p < 4; p++)
        for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
        for (int md = 0; md < 4; md++)
        for (int cd = 0; cd < 4; cd++)
        for (int sg = 0; sg < 2; sg++) begin
            bit ea, eb, ep;
            int jm;
            set_unit(0, rpat[p], md, cd, ipat[p]);
            set_unit(1, rpat[(p + 1) % 4], (md + 1) % 4, (cd + 2) % 4, ~ipat[p]);
            cfg_signed = sg[0];
            jm = (cd + p) % 4;
            cfg_join = 2'(jm);
            ea = model_hit(dpat[p], rpat[p], sz, off, md, cd, ipat[p], sg[0]);
            eb = model_hit(dpat[p], rpat[(p + 1) % 4], sz, off, (md + 1) % 4,
                           (cd + 2) % 4, ~ipat[p], sg[0]);
            ep = (jm == 1) ? (ea && eb) : (jm == 2) ? (ea || eb) : 1'b0;
            beat(dpat[p], sz, off);
            check("R7 unit0", hit_cmp[0], ea);
            check("R7 unit1", hit_cmp[1], eb);
            check("R9 pair", hit_pair, ep);
        end

        bus_valid = 1'b0;
        @(negedge clk);
        check("R2 final idle", hit_pair, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1'b1;
        $finish;
    end

endmodule